// File: doc/BRIEF.md
# Addressable Asynchronous Serial Receiver

This block is the receive half of an asynchronous serial port. It watches a single serial line and uses a tick that runs at sixteen times the bit rate to find start bits and take three votes near the middle of every bit. Frames are sent least significant bit first. There are two frame formats. The short format carries eight data bits. The long format carries a ninth bit after the data, which a multiprocessor bus uses to mark address bytes. A completed frame places its byte, and the ninth bit, on the output registers and raises a ready flag. A stop bit that reads low raises a sticky framing-error flag.

When address filtering is on, the block decides in hardware whether a frame concerns it, so that software sees the ready flag only when needed. In the long format a frame is taken only if its ninth bit is 1 and its byte matches one of two patterns built from the node's address and mask registers. One pattern is the node's own address. The other is a broadcast pattern. In the short format the filter takes a frame only when it has a valid stop bit. Both flags have clear strobes that software drives.

Top module: `serial_addr_rx`

## Requirements
- R1: Out of reset, rx_rdy, frame_err, rx_byte and rx_bit9 are all 0.
- R2: A frame is a low start bit, then data bits least significant first, then (in the long format, long_fmt=1) a ninth bit, then a stop bit. Each bit lasts 16 ticks. With filtering off, a completed frame loads rx_byte, and rx_bit9 (0 in the short format), and sets rx_rdy.
- R3: Each bit is read at ticks 7, 8 and 9 of its window, counting the tick that first saw the start edge as tick 0. The value of the bit is the majority of those three reads, so a single wrong read is outvoted.
- R4: If the majority of the reads of the start bit is high, the edge is dropped as noise. The receiver goes back to idle and no flag changes.
- R5: A stop bit whose majority reads low sets frame_err. frame_err stays set through later frames that have good stop bits, and it is cleared only by a pulse on clr_ferr.
- R6: In the long format with filtering off, every frame sets rx_rdy and places its ninth bit on rx_bit9.
- R7: In the long format with filt_en=1, a frame whose ninth bit is 1 is taken when (byte AND mask) equals (addr AND mask). Otherwise it is dropped, and rx_rdy and rx_byte keep their values.
- R8: In the long format with filt_en=1, a frame whose ninth bit is 1 is also taken when the byte has a 1 at every position where (addr OR mask) has a 1. The other positions do not matter.
- R9: In the long format with filt_en=1, a frame whose ninth bit is 0 is never taken, whatever its byte.
- R10: In the short format with filt_en=1, rx_rdy is set only if the stop bit is valid. With filtering off, a frame with a bad stop bit still sets rx_rdy. In both cases a bad stop bit sets frame_err.
- R11: While rx_rdy is 1, new frames do not overwrite rx_byte or rx_bit9. A pulse on clr_rdy clears rx_rdy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial line, already synchronised, idle high |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| long_fmt | input | 1 | 1 = nine-bit frames, 0 = eight-bit frames |
| filt_en | input | 1 | Address/stop filtering enable |
| node_addr | input | 8 | Node address register |
| node_mask | input | 8 | Address mask register |
| clr_rdy | input | 1 | Software clear of rx_rdy |
| clr_ferr | input | 1 | Software clear of frame_err |
| rx_byte | output | 8 | Last accepted data byte |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| rx_rdy | output | 1 | Receive-ready flag |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The bench places a one-tick glitch exactly on the middle vote of a data bit. A receiver that reads one sample would then pick up a flipped bit. It also sends a start pulse that falls short of mid-bit, which a receiver without start confirmation would turn into a phantom byte.

The address tests use one byte that only the node's own pattern accepts and one that only the broadcast pattern accepts. They also send a near-miss byte that lacks one required broadcast bit, and an address-looking byte with a zero ninth bit. A filter that confuses AND with OR, or that ignores the ninth bit, therefore raises the ready flag when it should not.

Further tests send good frames after a framing error, send a second frame while ready is still set, and send a bad stop bit in the short format with filtering both on and off. These catch a framing flag that clears itself, data that gets overwritten, and a stop condition that is applied in the wrong mode.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int unsigned DW   = 8;                 // data bits per frame
    localparam int unsigned OSR  = 16;                // ticks per bit
    localparam int unsigned CW   = $clog2(OSR);
    localparam int unsigned BW   = $clog2(DW + 2);
    localparam logic [CW-1:0] SMP_A = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] SMP_B = CW'(OSR / 2);
    localparam logic [CW-1:0] SMP_C = CW'(OSR / 2 + 1);
    localparam logic [CW-1:0] TICK_LAST = CW'(OSR - 1);

    typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_st_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          ninth;
        logic          stop_ok;
    } rx_frame_t;

    typedef struct packed {
        logic [DW-1:0] addr;
        logic [DW-1:0] mask;
    } addr_cfg_t;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    // own pattern: masked compare; broadcast: ones of (addr|mask) required
    function automatic logic addr_hit(input logic [DW-1:0] b, input addr_cfg_t c);
        logic [DW-1:0] bcast;
        bcast = c.addr | c.mask;
        return ((b & c.mask) == (c.addr & c.mask)) || ((b & bcast) == bcast);
    endfunction
endpackage

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
    import uart_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      line_i,
    input  logic      tick_i,
    input  logic      long_fmt_i,
    output logic      done_o,
    output rx_frame_t frame_o
);
    rx_st_e        st_q;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] idx_q;
    logic [1:0]    smp_q;
    logic [DW-1:0] sh_q;
    logic          ninth_q;
    logic          bit_v;
    logic [BW-1:0] lim;

    assign bit_v = vote3({line_i, smp_q[1], smp_q[0]});
    assign lim   = long_fmt_i ? BW'(DW + 1) : BW'(DW);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            smp_q   <= '0;
            sh_q    <= '0;
            ninth_q <= 1'b0;
            done_o  <= 1'b0;
            frame_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (tick_i) begin
                if (st_q == ST_IDLE) begin
                    if (!line_i) begin
                        st_q    <= ST_START;
                        cnt_q   <= CW'(1);
                        idx_q   <= '0;
                        ninth_q <= 1'b0;
                    end
                end else begin
                    cnt_q <= (cnt_q == TICK_LAST) ? '0 : cnt_q + CW'(1);
                    if (cnt_q == SMP_A) smp_q[0] <= line_i;
                    if (cnt_q == SMP_B) smp_q[1] <= line_i;
                    if (cnt_q == SMP_C) begin
                        case (st_q)
                            ST_START: if (bit_v) st_q <= ST_IDLE;
                            ST_DATA: begin
                                if (idx_q < BW'(DW)) sh_q <= {bit_v, sh_q[DW-1:1]};
                                else                 ninth_q <= bit_v;
                                idx_q <= idx_q + BW'(1);
                            end
                            ST_STOP: begin
                                st_q    <= ST_IDLE;
                                done_o  <= 1'b1;
                                frame_o <= '{data: sh_q, ninth: ninth_q, stop_ok: bit_v};
                            end
                            default: st_q <= ST_IDLE;
                        endcase
                    end
                    if (cnt_q == TICK_LAST) begin
                        if (st_q == ST_START)                    st_q <= ST_DATA;
                        else if (st_q == ST_DATA && idx_q == lim) st_q <= ST_STOP;
                    end
                end
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R2
    AST_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
        (done_o && !$past(done_o)) |-> $past(st_q == ST_STOP)); // R2
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import uart_rx_pkg::*;
(
    input  rx_frame_t frame_i,
    input  logic      long_fmt_i,
    input  logic      filt_en_i,
    input  addr_cfg_t cfg_i,
    output logic      accept_o
);
    always_comb begin
        if (!filt_en_i)      accept_o = 1'b1;
        else if (long_fmt_i) accept_o = frame_i.ninth && addr_hit(frame_i.data, cfg_i);
        else                 accept_o = frame_i.stop_ok;
    end
endmodule

// File: rtl/rx_status.sv
module rx_status
    import uart_rx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          done_i,
    input  rx_frame_t     frame_i,
    input  logic          accept_i,
    input  logic          clr_rdy_i,
    input  logic          clr_ferr_i,
    output logic [DW-1:0] data_o,
    output logic          bit9_o,
    output logic          rdy_o,
    output logic          ferr_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= '0;
            bit9_o <= 1'b0;
            rdy_o  <= 1'b0;
            ferr_o <= 1'b0;
        end else begin
            if (done_i && accept_i && !rdy_o) begin
                data_o <= frame_i.data;
                bit9_o <= frame_i.ninth;
                rdy_o  <= 1'b1;
            end else if (clr_rdy_i) begin
                rdy_o <= 1'b0;
            end
            if (done_i && !frame_i.stop_ok) ferr_o <= 1'b1;
            else if (clr_ferr_i)            ferr_o <= 1'b0;
        end
    end

    AST_RDY_FROM_FRAME: assert property (@(posedge clk) disable iff (rst)
        (rdy_o && !$past(rdy_o)) |-> $past(done_i)); // R2
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        $past(rdy_o) |-> ($stable(data_o) && $stable(bit9_o))); // R11
    AST_FERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!ferr_o && $past(ferr_o)) |-> $past(clr_ferr_i)); // R5
endmodule

// File: rtl/serial_addr_rx.sv
module serial_addr_rx
    import uart_rx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_line,
    input  logic          os_tick,
    input  logic          long_fmt,
    input  logic          filt_en,
    input  logic [DW-1:0] node_addr,
    input  logic [DW-1:0] node_mask,
    input  logic          clr_rdy,
    input  logic          clr_ferr,
    output logic [DW-1:0] rx_byte,
    output logic          rx_bit9,
    output logic          rx_rdy,
    output logic          frame_err
);
    logic      done;
    logic      accept;
    rx_frame_t frame;
    addr_cfg_t cfg;

    assign cfg = '{addr: node_addr, mask: node_mask};

    rx_bit_engine u_engine (
        .clk(clk), .rst(rst), .line_i(rx_line), .tick_i(os_tick),
        .long_fmt_i(long_fmt), .done_o(done), .frame_o(frame)
    );

    rx_addr_filter u_filter (
        .frame_i(frame), .long_fmt_i(long_fmt), .filt_en_i(filt_en),
        .cfg_i(cfg), .accept_o(accept)
    );

    rx_status u_status (
        .clk(clk), .rst(rst), .done_i(done), .frame_i(frame), .accept_i(accept),
        .clr_rdy_i(clr_rdy), .clr_ferr_i(clr_ferr), .data_o(rx_byte),
        .bit9_o(rx_bit9), .rdy_o(rx_rdy), .ferr_o(frame_err)
    );

    AST_FILTER_NINTH: assert property (@(posedge clk) disable iff (rst)
        (rx_rdy && !$past(rx_rdy) && $past(long_fmt && filt_en)) |-> rx_bit9); // R7
endmodule

// File: tb/tb_serial_addr_rx.sv
module tb_serial_addr_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic       long_fmt = 1'b0;
    logic       filt_en = 1'b0;
    logic [7:0] node_addr = 8'h00;
    logic [7:0] node_mask = 8'h00;
    logic       clr_rdy = 1'b0;
    logic       clr_ferr = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_bit9;
    logic       rx_rdy;
    logic       frame_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    serial_addr_rx dut (
        .clk(clk), .rst(rst), .rx_line(rx_line), .os_tick(os_tick),
        .long_fmt(long_fmt), .filt_en(filt_en), .node_addr(node_addr),
        .node_mask(node_mask), .clr_rdy(clr_rdy), .clr_ferr(clr_ferr),
        .rx_byte(rx_byte), .rx_bit9(rx_bit9), .rx_rdy(rx_rdy), .frame_err(frame_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic v);
        @(negedge clk); rx_line = v; os_tick = 1'b1;
        @(negedge clk); os_tick = 1'b0;
    endtask

    task automatic pulse_clr_rdy();
        @(negedge clk); clr_rdy = 1'b1;
        @(negedge clk); clr_rdy = 1'b0;
    endtask

    task automatic pulse_clr_ferr();
        @(negedge clk); clr_ferr = 1'b1;
        @(negedge clk); clr_ferr = 1'b0;
    endtask

    // gbit >= 0 flips tick 8 of that data bit only
    task automatic send(input logic [7:0] d, input logic b9, input logic stp, input int gbit);
        logic v;
        for (int t = 0; t < 16; t++) tick(1'b0);
        for (int i = 0; i < 8; i++)
            for (int t = 0; t < 16; t++) begin
                v = d[i];
                if (i == gbit && t == 8) v = ~v;
                tick(v);
            end
        if (long_fmt)
            for (int t = 0; t < 16; t++) tick(b9);
        for (int t = 0; t < 16; t++) tick(stp);
        for (int t = 0; t < 14; t++) tick(1'b1);
    endtask

    task automatic t_reset();
        chk("R1 rdy", rx_rdy, 0);
        chk("R1 ferr", frame_err, 0);
        chk("R1 byte", rx_byte, 0);
        chk("R1 bit9", rx_bit9, 0);
    endtask

    task automatic t_basic();
        long_fmt = 0; filt_en = 0;
        send(8'hA5, 1'b0, 1'b1, -1);
        chk("R2 rdy", rx_rdy, 1);
        chk("R2 byte", rx_byte, 8'hA5);
        chk("R2 bit9", rx_bit9, 0);
        pulse_clr_rdy();
        chk("R11 clear", rx_rdy, 0);
    endtask

    task automatic t_majority();
        send(8'h3C, 1'b0, 1'b1, 2);
        chk("R3 vote", rx_byte, 8'h3C);
        pulse_clr_rdy();
        send(8'h81, 1'b0, 1'b1, 0);
        chk("R3 vote lsb", rx_byte, 8'h81);
        pulse_clr_rdy();
    endtask

    task automatic t_glitch();
        for (int t = 0; t < 4; t++) tick(1'b0);
        for (int t = 0; t < 24; t++) tick(1'b1);
        chk("R4 no rdy", rx_rdy, 0);
        chk("R4 byte kept", rx_byte, 8'h81);
        send(8'h5A, 1'b0, 1'b1, -1);
        chk("R4 resync", rx_byte, 8'h5A);
        pulse_clr_rdy();
    endtask

    task automatic t_ferr();
        send(8'h11, 1'b0, 1'b0, -1);
        chk("R5 set", frame_err, 1);
        chk("R10 unfiltered rdy", rx_rdy, 1);
        pulse_clr_rdy();
        send(8'h22, 1'b0, 1'b1, -1);
        chk("R5 sticky", frame_err, 1);
        pulse_clr_rdy();
        pulse_clr_ferr();
        chk("R5 cleared", frame_err, 0);
    endtask

    task automatic t_short_filter();
        filt_en = 1;
        send(8'h33, 1'b0, 1'b0, -1);
        chk("R10 bad stop no rdy", rx_rdy, 0);
        chk("R10 ferr", frame_err, 1);
        pulse_clr_ferr();
        send(8'h44, 1'b0, 1'b1, -1);
        chk("R10 good stop rdy", rx_rdy, 1);
        chk("R10 byte", rx_byte, 8'h44);
        pulse_clr_rdy();
    endtask

    task automatic t_long_open();
        long_fmt = 1; filt_en = 0;
        send(8'h96, 1'b1, 1'b1, -1);
        chk("R6 rdy", rx_rdy, 1);
        chk("R6 byte", rx_byte, 8'h96);
        chk("R6 bit9 one", rx_bit9, 1);
        pulse_clr_rdy();
        send(8'h07, 1'b0, 1'b1, -1);
        chk("R6 bit9 zero", rx_bit9, 0);
        chk("R6 rdy0", rx_rdy, 1);
        pulse_clr_rdy();
    endtask

    task automatic t_addr();
        // own = 0x50 under mask 0xF0, broadcast = 0xFA
        filt_en = 1; node_addr = 8'h5A; node_mask = 8'hF0;
        send(8'h53, 1'b1, 1'b1, -1);
        chk("R7 own hit", rx_rdy, 1);
        chk("R7 own byte", rx_byte, 8'h53);
        pulse_clr_rdy();
        send(8'h63, 1'b1, 1'b1, -1);
        chk("R7 miss", rx_rdy, 0);
        chk("R7 miss byte", rx_byte, 8'h53);
        send(8'hFB, 1'b1, 1'b1, -1);
        chk("R8 bcast hit", rx_rdy, 1);
        chk("R8 bcast byte", rx_byte, 8'hFB);
        pulse_clr_rdy();
        send(8'hF8, 1'b1, 1'b1, -1);
        chk("R8 near miss", rx_rdy, 0);
        send(8'h55, 1'b0, 1'b1, -1);
        chk("R9 ninth zero", rx_rdy, 0);
        chk("R9 byte kept", rx_byte, 8'hFB);
    endtask

    task automatic t_hold();
        long_fmt = 0; filt_en = 0;
        send(8'h12, 1'b0, 1'b1, -1);
        chk("R11 first", rx_byte, 8'h12);
        send(8'h34, 1'b0, 1'b1, -1);
        chk("R11 no overwrite", rx_byte, 8'h12);
        chk("R11 still rdy", rx_rdy, 1);
        pulse_clr_rdy();
        chk("R11 cleared", rx_rdy, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_majority();
        t_glitch();
        t_ferr();
        t_short_filter();
        t_long_open();
        t_addr();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule